// File: doc/BRIEF.md
# Input Bus Auto-Poll Scheduler

This block keeps an attached input-device bus under periodic observation and handles the bus-related commands of a system management controller. A bus command in a special form loads a 16-bit device mask. Loading a nonzero mask starts a 30 ms poll period, counted in millisecond ticks. Loading a zero mask stops it. A separate command turns polling off. Each time the period expires, the block sends a poll to an external bus agent over a valid/ready port, unless an earlier event is still waiting for acknowledge. A poll that returns data leaves the raw bytes in the reply buffer and raises two event flags.

Ordinary bus commands are checked for a consistent length. A valid command is forwarded to the same agent. Its answer is stored with a status prefix: 0x01 and a byte count ahead of the data, or a single 0x00 byte when the answer is empty or the command was malformed. In both cases the input event flag is raised. When no bus is fitted, bus commands leave every piece of state untouched. The event flags and the reply stay in place until the host pulses the acknowledge input.

Top module: `autopoll_sched`

## Requirements
- R1: After reset, the mask output is 0, both event flags are low, the reply length is 0, no agent request is pending and `cmd_ready` is high.
- R2: A bus command (`cmd_op`=0) with a bus fitted, whose argument bytes 0 and 1 are 0x00 and 0x86, is a mask setting. It takes effect only when `cmd_argc` is exactly 4. The new mask is byte 2 (upper half) followed by byte 3 (lower half). Any other count in this form is ignored.
- R3: A mask setting equal to the current mask changes nothing, and the period in progress keeps its phase. A different nonzero mask restarts the period. A zero mask stops polling.
- R4: The poll goes out on the 30th `ms_tick` after the period starts (not on the 29th), with `agt_req_poll`=1 and the current mask on `agt_req_mask`.
- R5: On expiry, the poll is skipped when `evt_input` is high, when an agent transaction is outstanding, or when a command is accepted in the same cycle. Each expiry restarts the 30-tick period whether or not a poll was made.
- R6: A poll answer with a nonzero count n (at most 8) stores the raw bytes at reply bytes 0..n-1 with reply length n, and sets both `evt_input` and `evt_auto`. An answer with count 0 changes nothing.
- R7: The poll-off command (`cmd_op`=1) with a count of 0 clears the mask and stops polling, provided a bus is fitted. Any other count is ignored.
- R8: An ordinary bus command fails in any of these cases: its count is 2, its count exceeds 8, or its declared length (byte 2) exceeds the count minus 3 or exceeds 252. A failed command stores the single reply byte 0x00 with length 1, sets `evt_input` and sends nothing to the agent. A count below 2 is ignored.
- R9: A well-formed ordinary command sends the agent byte 0 as header and bytes 3 onward as data, with a data count equal to the count minus 3 and `agt_req_poll`=0. An answer of n>0 bytes is stored as 0x01, n, data, with length n+2. An empty answer is stored as 0x00 with length 1. Only `evt_input` is set.
- R10: When `bus_present` is low, a bus command or a poll-off command changes neither the mask, the events nor the reply, and starts no agent request.
- R11: A pulse on `evt_ack` clears both event flags and sets the reply length to 0.
- R12: A command accepted in the cycle the period expires wins. For an ordinary command, its own request reaches the agent instead of the poll. For a poll-off command, no poll is made and polling stops. `cmd_ready` is low while an agent transaction is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| bus_present | input | 1 | High when an input-device bus is fitted |
| cmd_valid | input | 1 | Command strobe |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 1 | 0 = bus command, 1 = poll-off |
| cmd_argc | input | 4 | Number of argument bytes |
| cmd_args | input | 64 | Argument bytes, byte i at bits 8i+7..8i |
| evt_ack | input | 1 | Acknowledge: clears events and reply |
| agt_req_valid | output | 1 | Request to bus agent valid |
| agt_req_ready | input | 1 | Agent accepts request |
| agt_req_poll | output | 1 | 1 = poll, 0 = ordinary command |
| agt_req_mask | output | 16 | Device mask for a poll |
| agt_req_head | output | 8 | Header byte of an ordinary command |
| agt_req_cnt | output | 4 | Data byte count of an ordinary command |
| agt_req_data | output | 64 | Data bytes of an ordinary command |
| agt_rsp_valid | input | 1 | Agent answer strobe |
| agt_rsp_cnt | input | 4 | Answer byte count (0..8) |
| agt_rsp_data | input | 64 | Answer bytes, byte i at bits 8i+7..8i |
| poll_mask | output | 16 | Current device mask |
| evt_input | output | 1 | Input-device event pending |
| evt_auto | output | 1 | Event came from an automatic poll |
| reply_len | output | 4 | Bytes valid in reply buffer |
| reply_buf | output | 80 | Reply bytes, byte i at bits 8i+7..8i |

## Verification
The period expiry and the acceptance of a host command can land on the same clock edge. The bench provokes this by counting 29 ticks after arming and then presenting a command together with the 30th tick. In one case the command is an ordinary request: the agent must see that request with the poll flag low and its header byte, the stored reply must carry the 0x01 prefix with `evt_auto` low, and a poll must follow exactly 30 ticks later. In the other case the command is a poll-off: no request may appear at all, and the mask must read zero.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;

    localparam int MASK_W = 16;

    // argument byte 1 value that marks a mask-setting bus command
    localparam logic [7:0] POLL_FORM_TAG = 8'h86;
    localparam logic [7:0] PREFIX_DATA   = 8'h01;
    localparam logic [7:0] PREFIX_NONE   = 8'h00;

    typedef enum logic {
        OP_BUS      = 1'b0,
        OP_POLL_OFF = 1'b1
    } ap_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } ap_state_e;

endpackage

// File: rtl/ap_timer.sv
module ap_timer #(
    parameter int PERIOD = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic cancel,
    output logic fire,
    output logic armed
);
    localparam int CNT_W = $clog2(PERIOD + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PERIOD);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d    = q;
        fire = q.armed && tick && (q.cnt == CNT_W'(1)) && !arm && !cancel;
        if (cancel) begin
            d.armed = 1'b0;
            d.cnt   = '0;
        end else if (arm) begin
            d.armed = 1'b1;
            d.cnt   = LOAD;
        end else if (q.armed && tick) begin
            d.cnt = (q.cnt == CNT_W'(1)) ? LOAD : q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign armed = q.armed;

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.armed |-> (q.cnt != '0 && q.cnt <= LOAD));

    // R3
    cancel_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !q.armed);

endmodule

// File: rtl/ap_cmd_decode.sv
module ap_cmd_decode
    import autopoll_pkg::*;
#(
    parameter int ARGC_W    = 4,
    parameter int ARGS_MAX  = 8,
    parameter int LEN_LIMIT = 252
) (
    input  logic              valid,
    input  logic              op,
    input  logic              bus_present,
    input  logic [ARGC_W-1:0] argc,
    input  logic [31:0]       args_lo,
    input  logic [MASK_W-1:0] cur_mask,
    output logic              mask_wr,
    output logic [MASK_W-1:0] mask_new,
    output logic              arm,
    output logic              cancel,
    output logic              go_req,
    output logic              go_fail
);
    logic [7:0] b0, b1, declen, argc8;
    logic       is_form;
    logic       len_bad;

    always_comb begin
        b0       = args_lo[7:0];
        b1       = args_lo[15:8];
        declen   = args_lo[23:16];
        argc8    = 8'(argc);
        is_form  = (b0 == 8'h00) && (b1 == POLL_FORM_TAG);
        len_bad  = (argc8 < 8'd3) || (int'(argc) > ARGS_MAX) ||
                   (declen > argc8 - 8'd3) || (int'(declen) > LEN_LIMIT);
        mask_new = {args_lo[23:16], args_lo[31:24]};
        mask_wr  = 1'b0;
        arm      = 1'b0;
        cancel   = 1'b0;
        go_req   = 1'b0;
        go_fail  = 1'b0;
        if (valid && bus_present) begin
            if (op == OP_BUS && argc >= ARGC_W'(2)) begin
                if (is_form) begin
                    if (argc == ARGC_W'(4) && mask_new != cur_mask) begin
                        mask_wr = 1'b1;
                        arm     = (mask_new != '0);
                        cancel  = (mask_new == '0);
                    end
                end else if (len_bad) begin
                    go_fail = 1'b1;
                end else begin
                    go_req = 1'b1;
                end
            end else if (op == OP_POLL_OFF && argc == '0 && cur_mask != '0) begin
                mask_wr  = 1'b1;
                mask_new = '0;
                cancel   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ap_reply_fmt.sv
module ap_reply_fmt
    import autopoll_pkg::*;
#(
    parameter int RSP_MAX = 8
) (
    input  logic                      is_poll,
    input  logic [RCNT_W-1:0]         rsp_cnt,
    input  logic [RSP_MAX*8-1:0]      rsp_data,
    output logic                      store,
    output logic                      set_auto,
    output logic [RLEN_W-1:0]         len,
    output logic [(RSP_MAX+2)*8-1:0]  rbuf
);
    localparam int RCNT_W    = $clog2(RSP_MAX + 1);
    localparam int REPLY_MAX = RSP_MAX + 2;
    localparam int RLEN_W    = $clog2(REPLY_MAX + 1);

    logic [RCNT_W-1:0] n;

    always_comb begin
        n = (int'(rsp_cnt) > RSP_MAX) ? RCNT_W'(RSP_MAX) : rsp_cnt;
        if (is_poll) begin
            store    = (n != '0);
            set_auto = (n != '0);
            len      = RLEN_W'(n);
            rbuf     = {16'h0000, rsp_data};
        end else begin
            store    = 1'b1;
            set_auto = 1'b0;
            if (n != '0) begin
                len  = RLEN_W'(n) + RLEN_W'(2);
                rbuf = {rsp_data, {{(8-RCNT_W){1'b0}}, n}, PREFIX_DATA};
            end else begin
                len  = RLEN_W'(1);
                rbuf = {{(REPLY_MAX*8-8){1'b0}}, PREFIX_NONE};
            end
        end
    end

endmodule

// File: rtl/autopoll_sched.sv
module autopoll_sched
    import autopoll_pkg::*;
#(
    parameter int POLL_PERIOD_MS = 30,
    parameter int ARGS_MAX       = 8,
    parameter int RSP_MAX        = 8,
    parameter int LEN_LIMIT      = 252,
    localparam int ARGC_W        = $clog2(ARGS_MAX + 1),
    localparam int RCNT_W        = $clog2(RSP_MAX + 1),
    localparam int REPLY_MAX     = RSP_MAX + 2,
    localparam int RLEN_W        = $clog2(REPLY_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ms_tick,
    input  logic                   bus_present,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic                   cmd_op,
    input  logic [ARGC_W-1:0]      cmd_argc,
    input  logic [ARGS_MAX*8-1:0]  cmd_args,
    input  logic                   evt_ack,
    output logic                   agt_req_valid,
    input  logic                   agt_req_ready,
    output logic                   agt_req_poll,
    output logic [MASK_W-1:0]      agt_req_mask,
    output logic [7:0]             agt_req_head,
    output logic [ARGC_W-1:0]      agt_req_cnt,
    output logic [ARGS_MAX*8-1:0]  agt_req_data,
    input  logic                   agt_rsp_valid,
    input  logic [RCNT_W-1:0]      agt_rsp_cnt,
    input  logic [RSP_MAX*8-1:0]   agt_rsp_data,
    output logic [MASK_W-1:0]      poll_mask,
    output logic                   evt_input,
    output logic                   evt_auto,
    output logic [RLEN_W-1:0]      reply_len,
    output logic [REPLY_MAX*8-1:0] reply_buf
);

    typedef struct packed {
        ap_state_e             st;
        logic                  is_poll;
        logic [MASK_W-1:0]     pmask;
        logic [7:0]            head;
        logic [ARGC_W-1:0]     cnt;
        logic [ARGS_MAX*8-1:0] data;
        logic                  evt_in;
        logic                  evt_at;
        logic [RLEN_W-1:0]     rlen;
        logic [REPLY_MAX*8-1:0] rbuf;
    } regs_t;

    regs_t d, q;

    logic cmd_fire;
    logic mask_wr, arm, cancel, go_req, go_fail;
    logic [MASK_W-1:0] mask_new;
    logic fire, armed;
    logic fmt_store, fmt_auto;
    logic [RLEN_W-1:0] fmt_len;
    logic [REPLY_MAX*8-1:0] fmt_buf;
    logic poll_go;

    assign cmd_ready = (q.st == ST_IDLE);
    assign cmd_fire  = cmd_valid && cmd_ready;

    ap_cmd_decode #(
        .ARGC_W   (ARGC_W),
        .ARGS_MAX (ARGS_MAX),
        .LEN_LIMIT(LEN_LIMIT)
    ) u_dec (
        .valid      (cmd_fire),
        .op         (cmd_op),
        .bus_present(bus_present),
        .argc       (cmd_argc),
        .args_lo    (cmd_args[31:0]),
        .cur_mask   (q.pmask),
        .mask_wr    (mask_wr),
        .mask_new   (mask_new),
        .arm        (arm),
        .cancel     (cancel),
        .go_req     (go_req),
        .go_fail    (go_fail)
    );

    ap_timer #(.PERIOD(POLL_PERIOD_MS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ms_tick),
        .arm   (arm),
        .cancel(cancel),
        .fire  (fire),
        .armed (armed)
    );

    ap_reply_fmt #(.RSP_MAX(RSP_MAX)) u_fmt (
        .is_poll (q.is_poll),
        .rsp_cnt (agt_rsp_cnt),
        .rsp_data(agt_rsp_data),
        .store   (fmt_store),
        .set_auto(fmt_auto),
        .len     (fmt_len),
        .rbuf    (fmt_buf)
    );

    // an expiry only turns into a poll when nothing else claims this cycle
    assign poll_go = fire && (q.st == ST_IDLE) && !cmd_fire && !q.evt_in;

    always_comb begin
        d = q;
        if (evt_ack) begin
            d.evt_in = 1'b0;
            d.evt_at = 1'b0;
            d.rlen   = '0;
        end
        if (mask_wr) d.pmask = mask_new;
        if (go_fail) begin
            d.rlen   = RLEN_W'(1);
            d.rbuf   = {{(REPLY_MAX*8-8){1'b0}}, PREFIX_NONE};
            d.evt_in = 1'b1;
        end
        unique case (q.st)
            ST_IDLE: begin
                if (go_req) begin
                    d.st      = ST_REQ;
                    d.is_poll = 1'b0;
                    d.head    = cmd_args[7:0];
                    d.cnt     = cmd_argc - ARGC_W'(3);
                    d.data    = cmd_args >> 24;
                end else if (poll_go) begin
                    d.st      = ST_REQ;
                    d.is_poll = 1'b1;
                end
            end
            ST_REQ: begin
                if (agt_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (agt_rsp_valid) begin
                    d.st = ST_IDLE;
                    if (fmt_store) begin
                        d.rlen   = fmt_len;
                        d.rbuf   = fmt_buf;
                        d.evt_in = 1'b1;
                    end
                    if (fmt_auto) d.evt_at = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign agt_req_valid = (q.st == ST_REQ);
    assign agt_req_poll  = q.is_poll;
    assign agt_req_mask  = q.pmask;
    assign agt_req_head  = q.head;
    assign agt_req_cnt   = q.cnt;
    assign agt_req_data  = q.data;
    assign poll_mask     = q.pmask;
    assign evt_input     = q.evt_in;
    assign evt_auto      = q.evt_at;
    assign reply_len     = q.rlen;
    assign reply_buf     = q.rbuf;

    // R4
    poll_mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (agt_req_valid && agt_req_poll) |-> (agt_req_mask != '0 && armed));

    // R5
    poll_skip_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (agt_req_valid && !$past(agt_req_valid) && agt_req_poll) |-> !$past(evt_input));

    // R6
    auto_implies_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_auto |-> evt_input);

    // R11
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ack && !agt_rsp_valid && !cmd_valid) |=> (!evt_input && !evt_auto && reply_len == '0));

    // R12
    busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        agt_req_valid |-> !cmd_ready);

    // R9
    reply_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reply_len <= RLEN_W'(REPLY_MAX));

endmodule

// File: tb/autopoll_sched_bench.sv
`timescale 1ns/1ps
module autopoll_sched_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ms_tick, bus_present, cmd_valid, cmd_op, evt_ack;
    logic [3:0]  cmd_argc;
    logic [63:0] cmd_args;
    logic        cmd_ready;
    logic        agt_req_valid, agt_req_ready, agt_req_poll;
    logic [15:0] agt_req_mask;
    logic [7:0]  agt_req_head;
    logic [3:0]  agt_req_cnt;
    logic [63:0] agt_req_data;
    logic        agt_rsp_valid;
    logic [3:0]  agt_rsp_cnt;
    logic [63:0] agt_rsp_data;
    logic [15:0] poll_mask;
    logic        evt_input, evt_auto;
    logic [3:0]  reply_len;
    logic [79:0] reply_buf;

    int n_chk = 0, n_fail = 0, n_req = 0;
    logic [3:0]  cfg_cnt = '0;
    logic [63:0] cfg_data = '0;
    logic        last_poll;
    logic [15:0] last_mask;
    logic [7:0]  last_head;
    logic [3:0]  last_cnt;
    logic [63:0] last_data;

    always #10 clk = ~clk;

    autopoll_sched u_autopoll_sched (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .bus_present(bus_present),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_argc(cmd_argc), .cmd_args(cmd_args), .evt_ack(evt_ack),
        .agt_req_valid(agt_req_valid), .agt_req_ready(agt_req_ready),
        .agt_req_poll(agt_req_poll), .agt_req_mask(agt_req_mask),
        .agt_req_head(agt_req_head), .agt_req_cnt(agt_req_cnt),
        .agt_req_data(agt_req_data), .agt_rsp_valid(agt_rsp_valid),
        .agt_rsp_cnt(agt_rsp_cnt), .agt_rsp_data(agt_rsp_data),
        .poll_mask(poll_mask), .evt_input(evt_input), .evt_auto(evt_auto),
        .reply_len(reply_len), .reply_buf(reply_buf)
    );

    // bus agent model: accepts at once, answers one cycle after acceptance
    initial begin
        logic pend;
        pend = 1'b0;
        agt_req_ready = 1'b1;
        agt_rsp_valid = 1'b0;
        agt_rsp_cnt   = '0;
        agt_rsp_data  = '0;
        forever begin
            @(negedge clk);
            agt_rsp_valid = 1'b0;
            if (pend) begin
                agt_rsp_valid = 1'b1;
                agt_rsp_cnt   = cfg_cnt;
                agt_rsp_data  = cfg_data;
                pend = 1'b0;
            end else if (agt_req_valid && agt_req_ready) begin
                n_req++;
                last_poll = agt_req_poll;
                last_mask = agt_req_mask;
                last_head = agt_req_head;
                last_cnt  = agt_req_cnt;
                last_data = agt_req_data;
                pend = 1'b1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pk(input logic [7:0] b0, b1, b2, b3, b4);
        return {24'h0, b4, b3, b2, b1, b0};
    endfunction

    function automatic logic [7:0] rbyte(input int i);
        return reply_buf[8*i +: 8];
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic send(input logic op, input logic [3:0] argc, input logic [63:0] args);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_argc = argc; cmd_args = args; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        idle(4);
    endtask

    task automatic ack();
        @(negedge clk); evt_ack = 1'b1;
        @(negedge clk); evt_ack = 1'b0;
    endtask

    task automatic set_mask(input logic [15:0] m);
        send(1'b0, 4'd4, pk(8'h00, 8'h86, m[15:8], m[7:0], 8'h00));
    endtask

    task automatic t_reset();
        chk("R1 mask", poll_mask, 0);
        chk("R1 evt_input", evt_input, 0);
        chk("R1 evt_auto", evt_auto, 0);
        chk("R1 reply_len", reply_len, 0);
        chk("R1 req_valid", agt_req_valid, 0);
        chk("R1 cmd_ready", cmd_ready, 1);
    endtask

    task automatic t_arm_and_poll();
        int base;
        cfg_cnt = 4'd2; cfg_data = 64'h2211;
        set_mask(16'h1234);
        chk("R2 mask loaded", poll_mask, 32'h1234);
        base = n_req;
        ticks(29); idle(4);
        chk("R4 no poll at tick 29", n_req, base);
        ticks(1); idle(4);
        chk("R4 poll at tick 30", n_req, base + 1);
        chk("R4 poll flag", last_poll, 1);
        chk("R4 poll mask", last_mask, 32'h1234);
        chk("R6 evt_input", evt_input, 1);
        chk("R6 evt_auto", evt_auto, 1);
        chk("R6 reply_len", reply_len, 2);
        chk("R6 byte0", rbyte(0), 32'h11);
        chk("R6 byte1", rbyte(1), 32'h22);
    endtask

    task automatic t_skip_and_rearm();
        int base;
        base = n_req;
        ticks(30); idle(4);
        chk("R5 skipped while pending", n_req, base);
        ack(); idle(1);
        chk("R11 evt_input cleared", evt_input, 0);
        chk("R11 evt_auto cleared", evt_auto, 0);
        chk("R11 reply_len cleared", reply_len, 0);
        cfg_cnt = 4'd0;
        ticks(30); idle(4);
        chk("R5 rearmed after skip", n_req, base + 1);
        chk("R6 empty poll no event", evt_input, 0);
        chk("R6 empty poll no reply", reply_len, 0);
    endtask

    task automatic t_same_and_zero_mask();
        int base;
        base = n_req;
        ticks(10);
        set_mask(16'h1234);
        ticks(20); idle(4);
        chk("R3 same mask keeps phase", n_req, base + 1);
        set_mask(16'h0001);
        ticks(29); idle(4);
        chk("R3 new mask restarts", n_req, base + 1);
        ticks(1); idle(4);
        chk("R3 new mask polls", n_req, base + 2);
        chk("R4 new mask carried", last_mask, 32'h0001);
        set_mask(16'h0000);
        chk("R3 zero mask", poll_mask, 0);
        ticks(40); idle(4);
        chk("R3 zero mask stops", n_req, base + 2);
        send(1'b0, 4'd3, pk(8'h00, 8'h86, 8'h55, 8'h00, 8'h00));
        chk("R2 wrong count ignored", poll_mask, 0);
        chk("R2 wrong count no event", evt_input, 0);
    endtask

    task automatic t_poll_off();
        int base;
        set_mask(16'h00F0);
        send(1'b1, 4'd1, '0);
        chk("R7 count 1 ignored", poll_mask, 32'h00F0);
        send(1'b1, 4'd0, '0);
        chk("R7 mask cleared", poll_mask, 0);
        base = n_req;
        ticks(40); idle(4);
        chk("R7 polling stopped", n_req, base);
    endtask

    task automatic t_explicit();
        int base;
        base = n_req;
        cfg_cnt = 4'd3; cfg_data = 64'hC3B2A1;
        send(1'b0, 4'd5, pk(8'h2C, 8'h01, 8'h02, 8'hD0, 8'hD1));
        chk("R9 request sent", n_req, base + 1);
        chk("R9 not a poll", last_poll, 0);
        chk("R9 header", last_head, 32'h2C);
        chk("R9 data count", last_cnt, 2);
        chk("R9 data bytes", last_data[15:0], 32'hD1D0);
        chk("R9 reply_len", reply_len, 5);
        chk("R9 prefix", rbyte(0), 32'h01);
        chk("R9 count byte", rbyte(1), 32'h03);
        chk("R9 data0", rbyte(2), 32'hA1);
        chk("R9 data2", rbyte(4), 32'hC3);
        chk("R9 evt_input", evt_input, 1);
        chk("R9 evt_auto low", evt_auto, 0);
        ack();
        cfg_cnt = 4'd0;
        send(1'b0, 4'd3, pk(8'h2C, 8'h01, 8'h00, 8'h00, 8'h00));
        chk("R9 empty reply len", reply_len, 1);
        chk("R9 empty reply byte", rbyte(0), 32'h00);
        chk("R9 empty reply event", evt_input, 1);
        ack();
    endtask

    task automatic t_fail();
        int base;
        base = n_req;
        send(1'b0, 4'd5, pk(8'h2C, 8'h01, 8'h03, 8'hD0, 8'hD1));
        chk("R8 long declared no request", n_req, base);
        chk("R8 fail reply len", reply_len, 1);
        chk("R8 fail reply byte", rbyte(0), 32'h00);
        chk("R8 fail event", evt_input, 1);
        ack();
        send(1'b0, 4'd2, pk(8'h2C, 8'h01, 8'h00, 8'h00, 8'h00));
        chk("R8 count 2 fails", reply_len, 1);
        chk("R8 count 2 event", evt_input, 1);
        ack();
        send(1'b0, 4'd1, pk(8'h2C, 8'h00, 8'h00, 8'h00, 8'h00));
        chk("R8 count 1 ignored", evt_input, 0);
        chk("R8 count 1 no reply", reply_len, 0);
        chk("R8 no request", n_req, base);
    endtask

    task automatic t_no_bus();
        int base;
        base = n_req;
        bus_present = 1'b0;
        send(1'b0, 4'd3, pk(8'h2C, 8'h01, 8'h00, 8'h00, 8'h00));
        chk("R10 no request", n_req, base);
        chk("R10 no event", evt_input, 0);
        chk("R10 no reply", reply_len, 0);
        set_mask(16'h0F00);
        chk("R10 mask untouched", poll_mask, 0);
        bus_present = 1'b1;
    endtask

    task automatic t_collide();
        int base;
        cfg_cnt = 4'd1; cfg_data = 64'h77;
        set_mask(16'h0F0F);
        base = n_req;
        ticks(29); idle(2);
        @(negedge clk);
        cmd_op = 1'b0; cmd_argc = 4'd3; cmd_args = pk(8'h3C, 8'h00, 8'h00, 8'h00, 8'h00);
        cmd_valid = 1'b1; ms_tick = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; ms_tick = 1'b0;
        idle(4);
        chk("R12 one request", n_req, base + 1);
        chk("R12 command wins", last_poll, 0);
        chk("R12 command header", last_head, 32'h3C);
        chk("R12 command reply prefix", rbyte(0), 32'h01);
        chk("R12 evt_auto low", evt_auto, 0);
        ack();
        ticks(30); idle(4);
        chk("R12 rearmed poll", n_req, base + 2);
        chk("R12 rearmed poll flag", last_poll, 1);
        ack();
        base = n_req;
        ticks(29); idle(2);
        @(negedge clk);
        cmd_op = 1'b1; cmd_argc = 4'd0; cmd_args = '0;
        cmd_valid = 1'b1; ms_tick = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; ms_tick = 1'b0;
        idle(4);
        chk("R12 poll-off beats expiry", n_req, base);
        chk("R12 mask cleared", poll_mask, 0);
        ticks(40); idle(4);
        chk("R12 stays stopped", n_req, base);
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ms_tick = 1'b0; bus_present = 1'b1; cmd_valid = 1'b0;
        cmd_op = 1'b0; cmd_argc = '0; cmd_args = '0; evt_ack = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_arm_and_poll();
        t_skip_and_rearm();
        t_same_and_zero_mask();
        t_poll_off();
        t_explicit();
        t_fail();
        t_no_bus();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule